// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block joins two 18-bit bidirectional buses, side A and side B, through two independent one-way paths: a forward path that carries A data onto B and a reverse path that carries B data onto A. Neither path inverts the data. Each path has one storage stage, governed by a pass control and a strobe control. While its pass control is high, the stage is transparent and the path's output follows its input in the same cycle. While the pass control is low, the stage holds its contents, and it reloads only on a detected rising edge of the strobe. Each path has its own output enable. The forward enable is active high and the reverse enable is active low.

The whole block runs on one system clock. The pass and strobe controls are sampled on that clock. A strobe rising edge is detected when the previously sampled strobe was 0 and the current strobe is 1. Each pad is split into an input, an output and an output enable. Each side also has an input flag that shows whether an external agent is driving that bus. When no agent drives a line, a per-bit keeper presents the last value the line carried.

Top module: `univ_bus_xcvr`

## Requirements
- R1: While `fwd_pass` is high and `fwd_oe` is high, `b_pad_o` equals the side-A data in the same cycle, bit for bit, without inversion. Side-A data is `a_pad_i` when `a_ext_drv` is 1, and the side-A keeper value otherwise.
- R2: While `fwd_pass` is low and no strobe rising edge is detected, the forward storage is unchanged and `b_pad_o` repeats its previous value.
- R3: While `fwd_pass` is low, a clock edge at which `fwd_strobe` is 1 and was 0 at the previous edge loads the side-A data of that cycle into the forward storage. `b_pad_o` shows the loaded value from the following cycle on.
- R4: When `fwd_pass` falls, the forward storage keeps the side-A data captured at the last clock edge at which `fwd_pass` was high.
- R5: `b_pad_oe` equals `fwd_oe`. While `fwd_oe` is 0, `b_pad_o` is all zeros.
- R6: The reverse path mirrors R1 to R4, using `rev_pass` and `rev_strobe`, with side-B data as its input and `a_pad_o` as its output. `a_pad_oe` is the inverse of `rev_oe_n`, and `a_pad_o` is all zeros while `rev_oe_n` is 1.
- R7: Each bit of a side's keeper takes the external input when that side's `*_ext_drv` is 1. Otherwise it takes the block's own output for that side when that output is enabled, and otherwise it keeps its value.
- R8: A synchronous `rst` clears both storage stages and both keepers to zero. It sets both previous-strobe samples to 1, so the first capture after reset needs the strobe to be seen low first. `rst` does not touch the enables.
- R9: With both output enables active and both pass controls low, each bus carries its own path's storage, independently of the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_pad_i | input | 18 | Value driven onto bus A by an external agent |
| a_ext_drv | input | 1 | An external agent drives bus A |
| a_pad_o | output | 18 | Value the block drives onto bus A |
| a_pad_oe | output | 1 | The block drives bus A |
| b_pad_i | input | 18 | Value driven onto bus B by an external agent |
| b_ext_drv | input | 1 | An external agent drives bus B |
| b_pad_o | output | 18 | Value the block drives onto bus B |
| b_pad_oe | output | 1 | The block drives bus B |
| fwd_oe | input | 1 | Forward (A to B) output enable, active high |
| fwd_pass | input | 1 | Forward transparent control |
| fwd_strobe | input | 1 | Forward capture strobe, rising edge loads |
| rev_oe_n | input | 1 | Reverse (B to A) output enable, active low |
| rev_pass | input | 1 | Reverse transparent control |
| rev_strobe | input | 1 | Reverse capture strobe, rising edge loads |

## Verification
The bench builds the block at its default width of 18, so every data bit is exercised with random words. Eight control bits make up the full control space: two enables, two pass controls, two strobes and two external-drive flags. The bench sweeps all 256 combinations several times in varying orders, so every transition between modes occurs, including strobe edges that land while the stage is holding, keeper fallback, and both enables active together. Directed sequences before the sweep cover the reset values, the pass-falling retention and the strobe-after-reset rule.

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_pad_i,
  input  logic             a_ext_drv,
  output logic [WIDTH-1:0] a_pad_o,
  output logic             a_pad_oe,
  input  logic [WIDTH-1:0] b_pad_i,
  input  logic             b_ext_drv,
  output logic [WIDTH-1:0] b_pad_o,
  output logic             b_pad_oe,
  input  logic             fwd_oe,
  input  logic             fwd_pass,
  input  logic             fwd_strobe,
  input  logic             rev_oe_n,
  input  logic             rev_pass,
  input  logic             rev_strobe
);

  logic [WIDTH-1:0] a_keep, b_keep, fwd_st, rev_st;
  logic [WIDTH-1:0] a_data, b_data, fwd_view, rev_view;
  logic             fwd_strobe_q, rev_strobe_q;
  logic             fwd_load, rev_load;

  assign a_data   = a_ext_drv ? a_pad_i : a_keep;
  assign b_data   = b_ext_drv ? b_pad_i : b_keep;
  assign fwd_view = fwd_pass ? a_data : fwd_st;
  assign rev_view = rev_pass ? b_data : rev_st;

  assign fwd_load = fwd_pass | (fwd_strobe & ~fwd_strobe_q);
  assign rev_load = rev_pass | (rev_strobe & ~rev_strobe_q);

  assign b_pad_oe = fwd_oe;
  assign a_pad_oe = ~rev_oe_n;
  assign b_pad_o  = b_pad_oe ? fwd_view : '0;
  assign a_pad_o  = a_pad_oe ? rev_view : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_st       <= '0;
      rev_st       <= '0;
      a_keep       <= '0;
      b_keep       <= '0;
      fwd_strobe_q <= 1'b1;
      rev_strobe_q <= 1'b1;
    end else begin
      if (fwd_load) fwd_st <= a_data;
      if (rev_load) rev_st <= b_data;
      fwd_strobe_q <= fwd_strobe;
      rev_strobe_q <= rev_strobe;
      if (a_ext_drv)     a_keep <= a_pad_i;
      else if (a_pad_oe) a_keep <= a_pad_o;
      if (b_ext_drv)     b_keep <= b_pad_i;
      else if (b_pad_oe) b_keep <= b_pad_o;
    end
  end

  // R2
  fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fwd_pass && !(fwd_strobe && !fwd_strobe_q)) |=> $stable(fwd_st));

  // R3
  fwd_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!fwd_pass && fwd_strobe && !fwd_strobe_q) |=> (fwd_st == $past(a_data)));

  // R4
  fwd_close_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_pass |=> (fwd_st == $past(a_data)));

  // R6
  rev_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!rev_pass && rev_strobe && !rev_strobe_q) |=> (rev_st == $past(b_data)));

  // R7
  a_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_ext_drv && !a_pad_oe) |=> $stable(a_keep));

endmodule

// File: tb/univ_bus_xcvr_test.sv
module univ_bus_xcvr_test;
  localparam int W = 18;

  logic clk = 0, rst = 1;
  logic [W-1:0] a_pad_i = '0, b_pad_i = '0;
  logic a_ext_drv = 0, b_ext_drv = 0;
  logic fwd_oe = 0, fwd_pass = 0, fwd_strobe = 0;
  logic rev_oe_n = 1, rev_pass = 0, rev_strobe = 0;
  logic [W-1:0] a_pad_o, b_pad_o;
  logic a_pad_oe, b_pad_oe;

  int n_cmp = 0, n_bad = 0;
  logic done = 0;

  logic [W-1:0] m_fst, m_rst, m_akeep, m_bkeep;
  logic m_fcp, m_rcp, m_fcap;

  univ_bus_xcvr #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst),
    .a_pad_i(a_pad_i), .a_ext_drv(a_ext_drv), .a_pad_o(a_pad_o), .a_pad_oe(a_pad_oe),
    .b_pad_i(b_pad_i), .b_ext_drv(b_ext_drv), .b_pad_o(b_pad_o), .b_pad_oe(b_pad_oe),
    .fwd_oe(fwd_oe), .fwd_pass(fwd_pass), .fwd_strobe(fwd_strobe),
    .rev_oe_n(rev_oe_n), .rev_pass(rev_pass), .rev_strobe(rev_strobe));

  always #10 clk = ~clk;

  function automatic logic [W-1:0] exp_b();
    logic [W-1:0] ad;
    ad = a_ext_drv ? a_pad_i : m_akeep;
    if (!fwd_oe) return '0;
    return fwd_pass ? ad : m_fst;
  endfunction

  function automatic logic [W-1:0] exp_a();
    logic [W-1:0] bd;
    bd = b_ext_drv ? b_pad_i : m_bkeep;
    if (rev_oe_n) return '0;
    return rev_pass ? bd : m_rst;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [W-1:0] ad, bd, eb, ea;
    ad = a_ext_drv ? a_pad_i : m_akeep;
    bd = b_ext_drv ? b_pad_i : m_bkeep;
    eb = exp_b();
    ea = exp_a();
    m_fcap = 0;
    if (rst) begin
      m_fst = '0; m_rst = '0; m_akeep = '0; m_bkeep = '0; m_fcp = 1; m_rcp = 1;
    end else begin
      if (fwd_pass) m_fst = ad;
      else if (fwd_strobe && !m_fcp) begin m_fst = ad; m_fcap = 1; end
      if (rev_pass || (rev_strobe && !m_rcp)) m_rst = bd;
      m_fcp = fwd_strobe;
      m_rcp = rev_strobe;
      if (a_ext_drv) m_akeep = a_pad_i; else if (!rev_oe_n) m_akeep = ea;
      if (b_ext_drv) m_bkeep = b_pad_i; else if (fwd_oe) m_bkeep = eb;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_all();
    string tb, ta;
    #1;
    if (!fwd_oe) tb = "R5";
    else if (fwd_pass && !a_ext_drv) tb = "R7";
    else if (fwd_pass) tb = "R1";
    else if (!rev_oe_n && !rev_pass) tb = "R9";
    else if (m_fcap) tb = "R3";
    else tb = "R2";
    ta = (!rev_oe_n && !fwd_oe) ? "R6" : (!rev_oe_n && !rev_pass && !fwd_pass) ? "R9" : "R6";
    check(tb, b_pad_o, exp_b());
    check(ta, a_pad_o, exp_a());
    check("R5", {{(W-1){1'b0}}, b_pad_oe}, {{(W-1){1'b0}}, fwd_oe});
    check("R6", {{(W-1){1'b0}}, a_pad_oe}, {{(W-1){1'b0}}, ~rev_oe_n});
  endtask

  initial begin
    m_fst = '0; m_rst = '0; m_akeep = '0; m_bkeep = '0; m_fcp = 1; m_rcp = 1; m_fcap = 0;
    @(negedge clk);
    step(); step();
    // R8: reset leaves storage zero, enables follow inputs
    fwd_oe = 1; rev_oe_n = 0; a_pad_i = 18'h3ffff; b_pad_i = 18'h2aaaa;
    #1;
    check("R8", b_pad_o, '0);
    check("R8", a_pad_o, '0);
    rst = 0;
    // R8: strobe already high after reset must not capture
    fwd_strobe = 1; a_ext_drv = 1;
    step(); #1;
    check("R8", b_pad_o, '0);
    fwd_strobe = 0; step();
    fwd_strobe = 1; step(); #1;
    check("R3", b_pad_o, 18'h3ffff);
    // R4: value at last pass-high edge stays after pass falls
    fwd_strobe = 0; fwd_pass = 1; a_pad_i = 18'h12345; step();
    a_pad_i = 18'h0abcd; fwd_pass = 0; #1;
    check("R4", b_pad_o, 18'h12345);
    step(); #1;
    check("R4", b_pad_o, 18'h12345);
    // R6: reverse capture with active-low enable
    b_ext_drv = 1; b_pad_i = 18'h15555; rev_strobe = 0; step();
    rev_strobe = 1; step(); #1;
    check("R6", a_pad_o, 18'h15555);
    // sweep over full control space
    for (int pass = 0; pass < 6; pass++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] c;
        c = 8'(i * (2 * pass + 1) + pass * 53);
        {fwd_oe, fwd_pass, fwd_strobe, rev_oe_n, rev_pass, rev_strobe, a_ext_drv, b_ext_drv} = c;
        a_pad_i = W'($urandom);
        b_pad_i = W'($urandom);
        check_all();
        step();
      end
    end
    // R7: no driver anywhere, keepers present last line values
    a_ext_drv = 0; b_ext_drv = 0; fwd_oe = 1; fwd_pass = 1; rev_oe_n = 1;
    check_all();
    step(); check_all();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual running expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule